// File: doc/BRIEF.md
# Lockable Backlight PWM Generator

This block produces the pulse-width-modulated drive for a display backlight. Software programs a period and a duty word through a small register port. A per-cycle counter then compares its count against a high-time threshold to generate one output pin. The bit-count field picks the resolution. The period keeps only its low bit-count bits. The duty word carries the integer high time in its top bit-count bits. Its remaining low bits form a fraction, which can spread an extra count across successive PWM cycles.

Period and duty writes land in a staged copy first. The staged set moves into the active set only when the period counter wraps, and only when the group is not locked. A lock bit holds staged values back so that several fields can be changed together. A global lock input can hold the group as well, unless the group is told to ignore it. A read-only pending flag shows that staged values have not yet reached the active set.

Top module: `bl_pwm_top`

## Requirements
- R1: The period register (address 0) holds the period count in bits [15:0] and the bit-count n in bits [19:16]. A bit-count of 0 means n = 16. The count used is P = period AND (2^n − 1). Each PWM cycle lasts P clocks, or 1 clock when P is 0.
- R2: The control register (address 1) holds the duty word in bits [15:0], fractional enable in bit 16 and output enable in bit 17. The integer high time is duty >> (16 − n). With fractional enable at 0 the output is high for exactly that many clocks at the start of each PWM cycle, and the low bits have no effect.
- R3: With fractional enable at 1, the fraction F = (duty << n) mod 2^16 is added to a 16-bit accumulator at every period wrap. When that addition carries, the PWM cycle that starts next has its high time lengthened by one clock. The accumulator is cleared whenever fractional enable is 0.
- R4: Output enable takes effect on the next clock without waiting for a period boundary. While it is 0 the output is low.
- R5: A high time of 0 gives a constantly low output. A high time equal to or greater than P gives a constantly high output.
- R6: The lock register (address 2) has lock in bit 0, ignore-global-lock in bit 1 and pending in bit 2, which is read-only. While the group is locked, writes to the period and duty fields only change the staged copy, and the output keeps its previous pattern.
- R7: Any write to address 0 or 1 sets pending. Pending clears at the first period wrap at which the group is not locked, which is the same edge at which the staged set becomes active.
- R8: The group counts as locked when lock is 1, or when the global lock input is 1 and ignore-global-lock is 0. With ignore-global-lock at 1, the global input has no effect.
- R9: The active period and duty values, and the high-time threshold, change only at a period wrap, so no PWM cycle mixes old and new settings.
- R10: Reads of addresses 0 and 1 return the staged values and the output enable. Reads of address 3 return 0.
- R11: After reset every register is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 period, 1 control, 2 lock) |
| wr_data | input | 20 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 20 | Read data, combinational from rd_addr |
| global_lock | input | 1 | Chip-wide lock request |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
On every cycle the assertions check four things. The counter stays inside the active period. The active set and the threshold stay frozen between wraps and while the group is locked. Pending falls only at a wrap. Clearing output enable forces the pin low on the next clock. Only the bench's scenarios can show the rest: the exact high-time counts for each bit-count and mask, the alternating stretch pattern from the fraction accumulator, the two saturating ends of the duty range, and that staged values arrive after an unlock or after ignore-global-lock is set. The bench's behavioural model is compared with the pin on every clock.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_LOCK   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    localparam int LK_LOCK_BIT = 0;
    localparam int LK_IGN_BIT  = 1;
    localparam int LK_PEND_BIT = 2;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int BCW = 4,
    parameter int DW  = W + BCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [1:0]     rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           global_lock,
    input  logic           wrap,
    output logic [W-1:0]   act_per,
    output logic [BCW-1:0] act_bc,
    output logic [BCW-1:0] nxt_bc,
    output logic [W-1:0]   nxt_duty,
    output logic           nxt_frac,
    output logic           out_en
);

    typedef struct packed {
        logic [W-1:0]   per;
        logic [BCW-1:0] bc;
        logic [W-1:0]   duty;
        logic           fr;
    } cfg_t;

    typedef struct packed {
        cfg_t sh;
        cfg_t ac;
        logic oen;
        logic lock;
        logic ign;
        logic pend;
    } st_t;

    st_t  st_d, st_q;
    cfg_t nxt_cfg;
    logic eff_lock;
    logic apply;

    always_comb begin
        st_d     = st_q;
        eff_lock = st_q.lock | (global_lock & ~st_q.ign);
        apply    = wrap & st_q.pend & ~eff_lock;
        nxt_cfg  = apply ? st_q.sh : st_q.ac;
        st_d.ac  = nxt_cfg;
        if (apply) st_d.pend = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_PERIOD: begin
                    st_d.sh.per = wr_data[W-1:0];
                    st_d.sh.bc  = wr_data[W+BCW-1:W];
                    st_d.pend   = 1'b1;
                end
                REG_CTRL: begin
                    st_d.sh.duty = wr_data[W-1:0];
                    st_d.sh.fr   = wr_data[W];
                    st_d.oen     = wr_data[W+1];
                    st_d.pend    = 1'b1;
                end
                REG_LOCK: begin
                    st_d.lock = wr_data[LK_LOCK_BIT];
                    st_d.ign  = wr_data[LK_IGN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            REG_PERIOD: begin
                rd_data[W-1:0]     = st_q.sh.per;
                rd_data[W+BCW-1:W] = st_q.sh.bc;
            end
            REG_CTRL: begin
                rd_data[W-1:0] = st_q.sh.duty;
                rd_data[W]     = st_q.sh.fr;
                rd_data[W+1]   = st_q.oen;
            end
            REG_LOCK: begin
                rd_data[LK_LOCK_BIT] = st_q.lock;
                rd_data[LK_IGN_BIT]  = st_q.ign;
                rd_data[LK_PEND_BIT] = st_q.pend;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_per  = st_q.ac.per;
    assign act_bc   = st_q.ac.bc;
    assign nxt_bc   = nxt_cfg.bc;
    assign nxt_duty = nxt_cfg.duty;
    assign nxt_frac = nxt_cfg.fr;
    assign out_en   = st_q.oen;

    // R6: a locked group keeps its active set
    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_lock |=> $stable(st_q.ac));

    // R8: global lock holds the group unless ignored
    assert_global_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (global_lock && !st_q.ign) |=> $stable(st_q.ac));

    // R9: the active set moves only on a wrap
    assert_apply_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.ac));

    // R7: pending falls only at a wrap
    assert_pend_clear_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend) |-> $past(wrap));

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
    parameter int W   = 16,
    parameter int BCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   act_per,
    input  logic [BCW-1:0] act_bc,
    input  logic [BCW-1:0] nxt_bc,
    input  logic [W-1:0]   nxt_duty,
    input  logic           nxt_frac,
    input  logic           out_en,
    output logic           wrap,
    output logic           pwm_out
);

    localparam int NW = BCW + 1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] acc;
        logic [W:0]   thr;
    } cst_t;

    cst_t cs_d, cs_q;

    function automatic logic [NW-1:0] eff_bits(input logic [BCW-1:0] b);
        return (b == '0) ? NW'(W) : {1'b0, b};
    endfunction

    logic [NW-1:0] n_act, n_nxt;
    logic [W:0]    per_mask, per_masked;
    logic [W-1:0]  last;
    logic [W-1:0]  int_part, frac_word;
    logic [W:0]    acc_sum;

    always_comb begin
        n_act      = eff_bits(act_bc);
        per_mask   = ((W+1)'(1) << n_act) - (W+1)'(1);
        per_masked = {1'b0, act_per} & per_mask;
        last       = (per_masked == '0) ? '0 : W'(per_masked - (W+1)'(1));
        wrap       = (cs_q.cnt >= last);

        n_nxt      = eff_bits(nxt_bc);
        int_part   = nxt_duty >> (NW'(W) - n_nxt);
        frac_word  = nxt_duty << n_nxt;
        acc_sum    = {1'b0, cs_q.acc} + {1'b0, frac_word};

        cs_d = cs_q;
        if (wrap) begin
            cs_d.cnt = '0;
            if (nxt_frac) begin
                cs_d.acc = acc_sum[W-1:0];
                cs_d.thr = {1'b0, int_part} + (W+1)'(acc_sum[W]);
            end else begin
                cs_d.acc = '0;
                cs_d.thr = {1'b0, int_part};
            end
        end else begin
            cs_d.cnt = cs_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign pwm_out = out_en & ({1'b0, cs_q.cnt} < cs_q.thr);

    // R1: the counter never passes the last count of the active period
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.cnt <= last);

    // R9: the threshold holds for a whole PWM cycle
    assert_thr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cs_q.thr));

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [W+$clog2(W)-1:0]    wr_data,
    input  logic [1:0]                rd_addr,
    output logic [W+$clog2(W)-1:0]    rd_data,
    input  logic                      global_lock,
    output logic                      pwm_out
);

    localparam int BCW = $clog2(W);
    localparam int DW  = W + BCW;

    logic [W-1:0]   act_per;
    logic [BCW-1:0] act_bc, nxt_bc;
    logic [W-1:0]   nxt_duty;
    logic           nxt_frac, out_en, wrap;

    bl_pwm_regs #(.W(W), .BCW(BCW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .global_lock(global_lock), .wrap(wrap), .act_per(act_per),
        .act_bc(act_bc), .nxt_bc(nxt_bc), .nxt_duty(nxt_duty),
        .nxt_frac(nxt_frac), .out_en(out_en)
    );

    bl_pwm_core #(.W(W), .BCW(BCW)) u_core (
        .clk(clk), .rst_n(rst_n), .act_per(act_per), .act_bc(act_bc),
        .nxt_bc(nxt_bc), .nxt_duty(nxt_duty), .nxt_frac(nxt_frac),
        .out_en(out_en), .wrap(wrap), .pwm_out(pwm_out)
    );

    // R4: clearing output enable silences the pin on the next clock
    assert_out_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_CTRL && !wr_data[W+1]) |=> !pwm_out);

endmodule

// File: tb/tb_bl_pwm_top.sv
module tb_bl_pwm_top;

    localparam int CLK_PERIOD = 10;
    localparam int OEN  = 1 << 17;
    localparam int FREN = 1 << 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [19:0] rd_data;
    logic        global_lock = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    bl_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .global_lock(global_lock), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int s_per, s_bc, s_duty, s_fr, a_per, a_bc, a_duty, a_fr;
    int m_oen, m_lock, m_ign, m_pend, m_cnt, m_acc, m_thr;

    always @(posedge clk) begin
        int n, msk, lst, n2, ip, fw, sum;
        bit wr, ap;
        if (!rst_n) begin
            s_per = 0; s_bc = 0; s_duty = 0; s_fr = 0;
            a_per = 0; a_bc = 0; a_duty = 0; a_fr = 0;
            m_oen = 0; m_lock = 0; m_ign = 0; m_pend = 0;
            m_cnt = 0; m_acc = 0; m_thr = 0;
        end else begin
            n   = (a_bc == 0) ? 16 : a_bc;
            msk = a_per & ((1 << n) - 1);
            lst = (msk == 0) ? 0 : msk - 1;
            wr  = (m_cnt >= lst);
            ap  = wr && m_pend != 0 && !(m_lock != 0 || (global_lock && m_ign == 0));
            if (ap) begin
                a_per = s_per; a_bc = s_bc; a_duty = s_duty; a_fr = s_fr;
                m_pend = 0;
            end
            if (wr) begin
                m_cnt = 0;
                n2 = (a_bc == 0) ? 16 : a_bc;
                ip = a_duty >> (16 - n2);
                fw = (a_duty << n2) & 32'hFFFF;
                if (a_fr != 0) begin
                    sum = m_acc + fw;
                    m_acc = sum & 32'hFFFF;
                    m_thr = ip + (sum >> 16);
                end else begin
                    m_acc = 0;
                    m_thr = ip;
                end
            end else begin
                m_cnt++;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin s_per = wr_data[15:0]; s_bc = wr_data[19:16]; m_pend = 1; end
                    2'd1: begin s_duty = wr_data[15:0]; s_fr = wr_data[16]; m_oen = wr_data[17]; m_pend = 1; end
                    2'd2: begin m_lock = wr_data[0]; m_ign = wr_data[1]; end
                    default: ;
                endcase
            end
        end
    end

    // R9 and R2: pin compared against the model on every clock
    always @(negedge clk) begin
        bit e;
        if (rst_n && !done) begin
            e = (m_oen != 0) && (m_cnt < m_thr);
            checks++;
            if (pwm_out !== e) begin
                fails++;
                $display("FAIL R9 per-clock pwm_out: actual %0b expected %0b at %0t", pwm_out, e, $time);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 20'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 2'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, h;
        wait_clk(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(pwm_out == 1'b0, "R11 pwm after reset", int'(pwm_out), 0);
        rd(0, v); check(v == 0, "R11 period after reset", v, 0);
        rd(1, v); check(v == 0, "R11 ctrl after reset", v, 0);
        rd(2, v); check(v == 0, "R11 lock after reset", v, 0);

        // R1 R2: 16-bit mode, period 10, high 3
        wr(0, 10);
        wr(1, 3 | OEN);
        rd(2, v); check(v == 4, "R7 pending after unlocked write", v, 4);
        wait_clk(25);
        rd(2, v); check(v == 0, "R7 pending cleared at wrap", v, 0);
        count_high(20, h); check(h == 6, "R2 high count 16-bit mode", h, 6);

        // R1: bit-count 4 masks period 0xFFF5 down to 5
        wr(0, (4 << 16) | 16'hFFF5);
        wr(1, 16'h2000 | OEN);
        wait_clk(15);
        count_high(20, h); check(h == 8, "R1 masked period 5 high 2", h, 8);

        // R10: readback of staged values, address 3 reads zero
        rd(0, v); check(v == ((4 << 16) | 16'hFFF5), "R10 period readback", v, (4 << 16) | 16'hFFF5);
        rd(3, v); check(v == 0, "R10 unused address", v, 0);

        // R3: fraction one half, period 4, integer 1
        wr(0, (4 << 16) | 4);
        wr(1, 16'h1800 | FREN | OEN);
        wait_clk(20);
        count_high(32, h); check(h == 12, "R3 fractional stretch", h, 12);
        wr(1, 16'h1800 | OEN);
        wait_clk(12);
        count_high(32, h); check(h == 8, "R2 fraction ignored when disabled", h, 8);

        // R5: both saturating ends
        wr(0, (4 << 16) | 5);
        wr(1, OEN);
        wait_clk(12);
        count_high(20, h); check(h == 0, "R5 zero duty constant low", h, 0);
        wr(1, 16'hF000 | OEN);
        wait_clk(12);
        count_high(20, h); check(h == 20, "R5 duty over period constant high", h, 20);

        // R4: output enable takes effect on the next clock
        wr(1, 16'hF000);
        check(pwm_out == 1'b0, "R4 pin low right after disable", int'(pwm_out), 0);
        count_high(10, h); check(h == 0, "R4 pin stays low", h, 0);

        // R6 R7: lock stages writes
        wr(1, 16'h2000 | OEN);
        wait_clk(12);
        wr(2, 1);
        wr(1, 16'h4000 | OEN);
        wait_clk(3);
        rd(2, v); check(v == 5, "R7 pending while locked", v, 5);
        rd(1, v); check(v == (16'h4000 | OEN), "R10 staged duty readback", v, 16'h4000 | OEN);
        count_high(20, h); check(h == 8, "R6 old duty kept while locked", h, 8);
        wr(2, 0);
        wait_clk(8);
        rd(2, v); check(v == 0, "R7 pending cleared after unlock", v, 0);
        wait_clk(5);
        count_high(20, h); check(h == 16, "R9 staged duty applied after unlock", h, 16);

        // R8: global lock, then ignored
        global_lock = 1'b1;
        wr(1, 16'h1000 | OEN);
        wait_clk(10);
        count_high(20, h); check(h == 16, "R8 global lock holds old duty", h, 16);
        rd(2, v); check(v == 4, "R8 pending under global lock", v, 4);
        wr(2, 2);
        wait_clk(8);
        rd(2, v); check(v == 2, "R8 ignore bit releases update", v, 2);
        wait_clk(5);
        count_high(20, h); check(h == 4, "R8 new duty after ignore", h, 4);
        global_lock = 1'b0;

        wait_clk(5);
        finish_run();
    end

endmodule